// File: doc/BRIEF.md
# PHY Management Frame Master

This block produces clause-22 style management frames on a two-wire PHY management pair: a management clock it drives and a bidirectional data line that it drives through a separate output enable and reads back on its own input. A client asks for one register access at a time. It pulses a start strobe and at the same time presents a read/write select, a 5-bit PHY address, a 5-bit register address and, for a write, 16 data bits. The block sends the whole frame and raises a one-cycle done pulse when it ends. After a read, the captured 16-bit value is held on the read-data output.

Every bit on the line is built from management-clock phases. Each phase lasts `HALF_DIV` system clocks. A transmitted bit uses three phases: clock low, clock high, clock low. A received bit uses two phases: clock high, during which the line is sampled at the end of the phase, then clock low. Reads and writes finish differently. A read lets go of the line for one full low/high/low clock before it captures data. A write sends an explicit turnaround pair and then lets go of the line for one low phase.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Every frame opens with 32 driven bits that are all 1.
- R2: After the 32 ones the block drives the start pair 0,1 and then the opcode. The opcode is 1,0 for a read (`read_i`=1) and 0,1 for a write (`read_i`=0).
- R3: The PHY address and then the register address follow the opcode, 5 bits each, most significant bit first.
- R4: A write drives 64 bits in total. After the register address it drives the turnaround 1,0 and then the 16 write-data bits, most significant bit first. It then drops the output enable while the clock is low and holds the clock low for one more phase before done. It never shows a rising clock edge with the output enable low.
- R5: A read drives 46 bits, which end with the register address. It then shows 17 rising clock edges with the output enable low: one release edge, then 16 data edges. On those edges `mdio_i` is sampled while the clock is high, most significant bit first, and the value appears on `rdata_o`.
- R6: Every high phase of the clock lasts exactly `HALF_DIV` system clocks. A write takes 193 phases from accept to done and a read takes 173 phases.
- R7: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` rises. In that cycle `busy_o` is low. `done_o` is high for exactly one system clock.
- R8: A start strobe that arrives while a frame is in progress has no effect. The frame in flight is unchanged and no extra frame follows.
- R9: `rdata_o` changes only when the 16th data bit is sampled. It does not change during a write.
- R10: After reset the clock, the output enable, `busy_o`, `done_o` and `rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| read_i | input | 1 | 1 = read access, 0 = write access |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data for a write access |
| rdata_o | output | 16 | Data captured by the last read |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven on the line |
| mdio_oe_o | output | 1 | 1 = the block drives the data line |
| mdio_i | input | 1 | Value read back from the data line |

## Verification
Two situations are hard to reach from the ports: a start strobe that lands in the middle of a frame, and a read-data register that might update before the final sampled bit. The bench drives a second strobe with every field inverted partway through a read. It checks that the captured frame still matches the first request and that no second done follows. A small behavioural PHY model counts the rising clock edges taken with the output enable low and places each response bit on the line at that edge. Any change of `rdata_o` seen before the 17th such edge is flagged, and the exact phase count from accept to done is compared for both frame kinds.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    localparam int PRE_W   = 32;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = PRE_W + 4 + 2 * ADDR_W + 2 + DATA_W;   // 64
    localparam int HDR_W   = PRE_W + 4 + 2 * ADDR_W;                // 46
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_TURN,
        S_RECV,
        S_PARK
    } seq_e;

    typedef struct packed {
        seq_e               st;
        logic [1:0]         ph;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic               is_rd;
        logic [DATA_W-1:0]  acc;
        logic [DATA_W-1:0]  rdata;
        logic               done;
        logic               mdc;
        logic               oe;
        logic               mdo;
    } ctl_t;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int unsigned HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear_i || cnt_q == W'(HALF - 1)) cnt_d = '0;
        else                                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == W'(HALF - 1));

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !clear_i) |=> !tick_o);

endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
    import mdio_master_pkg::*;
(
    input  logic               rd_i,
    input  logic [ADDR_W-1:0]  phy_i,
    input  logic [ADDR_W-1:0]  reg_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   last_o
);
    localparam logic [1:0] ST_BITS = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_BITS = 2'b10;

    always_comb begin
        if (rd_i) begin
            frame_o = {{PRE_W{1'b1}}, ST_BITS, OP_RD, phy_i, reg_i,
                       {(FRAME_W - HDR_W){1'b0}}};
            last_o  = CNT_W'(HDR_W - 1);
        end else begin
            frame_o = {{PRE_W{1'b1}}, ST_BITS, OP_WR, phy_i, reg_i,
                       TA_BITS, wdata_i};
            last_o  = CNT_W'(FRAME_W - 1);
        end
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_master_pkg::*;
#(
    parameter int unsigned HALF_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              read_i,
    input  logic [4:0]        phy_addr_i,
    input  logic [4:0]        reg_addr_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    ctl_t q, n;

    logic               tick;
    logic               accept;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   last;

    assign accept = (q.st == S_IDLE) && start_i;

    mdio_phase_timer #(.HALF(HALF_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .tick_o  (tick)
    );

    mdio_frame_build u_build (
        .rd_i    (read_i),
        .phy_i   (phy_addr_i),
        .reg_i   (reg_addr_i),
        .wdata_i (wdata_i),
        .frame_o (frame),
        .last_o  (last)
    );

    always_comb begin
        n      = q;
        n.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    n.st    = S_SEND;
                    n.ph    = 2'd0;
                    n.sh    = frame;
                    n.cnt   = last;
                    n.is_rd = read_i;
                end
            end
            S_SEND: begin
                if (tick) begin
                    if (q.ph != 2'd2) begin
                        n.ph = q.ph + 2'd1;
                    end else if (q.cnt == '0) begin
                        n.ph = 2'd0;
                        n.st = q.is_rd ? S_TURN : S_PARK;
                    end else begin
                        n.ph  = 2'd0;
                        n.cnt = q.cnt - 1'b1;
                        n.sh  = {q.sh[FRAME_W-2:0], 1'b0};
                    end
                end
            end
            S_TURN: begin
                if (tick) begin
                    if (q.ph != 2'd2) begin
                        n.ph = q.ph + 2'd1;
                    end else begin
                        n.ph  = 2'd0;
                        n.st  = S_RECV;
                        n.cnt = CNT_W'(DATA_W - 1);
                    end
                end
            end
            S_RECV: begin
                if (tick) begin
                    if (q.ph == 2'd0) begin
                        n.acc = {q.acc[DATA_W-2:0], mdio_i};
                        if (q.cnt == '0) n.rdata = {q.acc[DATA_W-2:0], mdio_i};
                        n.ph = 2'd1;
                    end else if (q.cnt == '0) begin
                        n.st   = S_IDLE;
                        n.done = 1'b1;
                    end else begin
                        n.ph  = 2'd0;
                        n.cnt = q.cnt - 1'b1;
                    end
                end
            end
            S_PARK: begin
                if (tick) begin
                    n.st   = S_IDLE;
                    n.done = 1'b1;
                end
            end
            default: n = q;
        endcase

        // pin levels follow the next state so they leave a register
        unique case (n.st)
            S_SEND: begin
                n.mdc = (n.ph == 2'd1);
                n.oe  = 1'b1;
                n.mdo = n.sh[FRAME_W-1];
            end
            S_TURN: begin
                n.mdc = (n.ph == 2'd1);
                n.oe  = 1'b0;
                n.mdo = 1'b0;
            end
            S_RECV: begin
                n.mdc = (n.ph == 2'd0);
                n.oe  = 1'b0;
                n.mdo = 1'b0;
            end
            default: begin
                n.mdc = 1'b0;
                n.oe  = 1'b0;
                n.mdo = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, ph: 2'd0, cnt: '0, sh: '0, is_rd: 1'b0,
                   acc: '0, rdata: '0, done: 1'b0, mdc: 1'b0, oe: 1'b0,
                   mdo: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign rdata_o   = q.rdata;
    assign busy_o    = (q.st != S_IDLE);
    assign done_o    = q.done;
    assign mdc_o     = q.mdc;
    assign mdio_o    = q.mdo;
    assign mdio_oe_o = q.oe;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R8
    kind_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q.is_rd));

    // R6
    mdc_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc_o) |-> $past(tick || accept));

    // R4
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe_o) |-> !mdc_o);

    // R9
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> $past(busy_o && q.is_rd));

endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;

    localparam int unsigned HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd = 1'b0;
    logic [4:0]  phy = '0;
    logic [4:0]  rg = '0;
    logic [15:0] wd = '0;
    logic        mdi = 1'b0;
    logic [15:0] rdata;
    logic        busy, done, mdc, mdo, oe;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mdio_mgmt_master #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .read_i(rd),
        .phy_addr_i(phy), .reg_addr_i(rg), .wdata_i(wd),
        .rdata_o(rdata), .busy_o(busy), .done_o(done),
        .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdi)
    );

    // rd | phy | reg | wdata | phy response
    localparam logic [42:0] VECS [0:5] = '{
        {1'b0, 5'd1,  5'd0,  16'h8000, 16'h0000},
        {1'b1, 5'd1,  5'd1,  16'h0000, 16'h796D},
        {1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
        {1'b1, 5'd0,  5'd4,  16'h0000, 16'h0001},
        {1'b1, 5'd21, 5'd10, 16'h0000, 16'hFFFF},
        {1'b0, 5'd10, 5'd21, 16'h0001, 16'h0000}
    };

    // behavioural PHY / line monitor
    logic [63:0] cap;
    int ncap, nrel, badhi, hirun, early, badrel;
    logic [15:0] resp;
    logic mdc_prev = 1'b0, oe_prev = 1'b0;
    logic [15:0] rdata_prev = '0;

    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            if (oe) begin
                cap = {cap[62:0], mdo};
                ncap++;
            end else begin
                if (nrel >= 1 && nrel <= 16) mdi = resp[16 - nrel];
                nrel++;
            end
        end
        if (mdc) hirun++;
        else if (mdc_prev) begin
            if (hirun != HALF) badhi++;
            hirun = 0;
        end
        if (!oe && oe_prev && mdc) badrel++;
        if (rdata != rdata_prev && nrel < 17) early++;
        rdata_prev = rdata;
        mdc_prev = mdc;
        oe_prev = oe;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [42:0] v, input bit interfere);
        int n;
        int busylow;
        logic [15:0] old;
        logic vr;
        logic [4:0] vp, va;
        logic [15:0] vw, vresp;
        vr = v[42]; vp = v[41:37]; va = v[36:32]; vw = v[31:16]; vresp = v[15:0];
        cap = '0; ncap = 0; nrel = 0; badhi = 0; hirun = 0; early = 0; badrel = 0;
        resp = vresp;
        old = rdata;
        start = 1'b1; rd = vr; phy = vp; rg = va; wd = vw;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
        n = 0;
        busylow = 0;
        while (!done && n < 2000) begin
            if (!busy) busylow++;
            if (interfere && n == 30) begin
                start = 1'b1; rd = ~vr; phy = ~vp; rg = ~va; wd = ~vw;
            end else begin
                start = 1'b0;
            end
            if (vr && nrel < 17)
                chk(rdata == old, "R9 rdata held mid-read", 64'(rdata), 64'(old));
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R7 done reached", 64'(done), 64'd1);
        chk(busylow == 0, "R7 busy held", 64'(busylow), 64'd0);
        chk(busy == 1'b0, "R7 busy low with done", 64'(busy), 64'd0);
        chk(n == (vr ? 173 : 193) * HALF, "R6 frame length", 64'(n),
            64'((vr ? 173 : 193) * HALF));
        chk(badhi == 0, "R6 mdc high width", 64'(badhi), 64'd0);
        if (vr) begin
            chk(ncap == 46, "R5 driven bit count", 64'(ncap), 64'd46);
            chk(cap[45:14] == 32'hFFFF_FFFF, "R1 preamble", 64'(cap[45:14]), 64'hFFFF_FFFF);
            chk(cap[13:10] == 4'b0110, "R2 start+read op", 64'(cap[13:10]), 64'h6);
            chk(cap[9:0] == {vp, va}, "R3 addresses", 64'(cap[9:0]), 64'({vp, va}));
            chk(nrel == 17, "R5 released edges", 64'(nrel), 64'd17);
            chk(rdata == vresp, "R5 read data", 64'(rdata), 64'(vresp));
            chk(early == 0, "R9 early rdata change", 64'(early), 64'd0);
        end else begin
            chk(ncap == 64, "R4 driven bit count", 64'(ncap), 64'd64);
            chk(cap[63:32] == 32'hFFFF_FFFF, "R1 preamble", 64'(cap[63:32]), 64'hFFFF_FFFF);
            chk(cap[31:28] == 4'b0101, "R2 start+write op", 64'(cap[31:28]), 64'h5);
            chk(cap[27:18] == {vp, va}, "R3 addresses", 64'(cap[27:18]), 64'({vp, va}));
            chk(cap[17:0] == {2'b10, vw}, "R4 turnaround+data", 64'(cap[17:0]), 64'({2'b10, vw}));
            chk(nrel == 0 && badrel == 0, "R4 no released edge", 64'(nrel + badrel), 64'd0);
            chk(oe == 1'b0 && mdc == 1'b0, "R4 parked low", 64'({oe, mdc}), 64'd0);
            chk(rdata == old, "R9 rdata untouched by write", 64'(rdata), 64'(old));
        end
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
        if (interfere) begin
            n = 0;
            for (int k = 0; k < 40; k++) begin
                if (busy || done) n++;
                @(negedge clk);
            end
            chk(n == 0, "R8 ignored start left no frame", 64'(n), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({mdc, oe, busy, done} == 4'b0, "R10 reset pins", 64'({mdc, oe, busy, done}), 64'd0);
        chk(rdata == 16'h0, "R10 reset rdata", 64'(rdata), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mdc == 1'b0, "R10 idle after reset", 64'({busy, mdc}), 64'd0);
        for (int i = 0; i < 6; i++) run_frame(VECS[i], 1'b0);
        // R8: second strobe with all fields inverted mid-read
        run_frame({1'b1, 5'd9, 5'd2, 16'h0000, 16'hA5C3}, 1'b1);
        // R8: same during a write
        run_frame({1'b0, 5'd3, 5'd17, 16'h1234, 16'h0000}, 1'b1);
        // back-to-back read right after done
        run_frame({1'b1, 5'd30, 5'd0, 16'h0000, 16'h8001}, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule